// File: doc/BRIEF.md
# Block Compare Search Sequencer

This block executes the compare-and-step operation of an 8-bit processor's block search instructions, either as a single step or as a self-repeating run. It holds the accumulator, a 16-bit pointer, a 16-bit down-counter and the flag byte. Each iteration fetches one byte at the pointer through a request/valid read port, subtracts it from the accumulator without writing the result back, moves the pointer up or down, decrements the counter and rewrites the flags, including the two undocumented bits.

In repeat mode the block keeps iterating until the counter reaches zero or a byte equal to the accumulator is found. After each iteration it reports the number of clock cycles that iteration used. The surrounding core loads the register state while the block is idle, raises `start`, and waits for `done`.

Top module: `blkcmp_seq`

## Requirements
- R1: After reset, acc, hl, bc and flags are zero, and busy, done, mem_req and iter_stb are low.
- R2: When idle and start is low, ld_en copies ld_acc, ld_hl, ld_bc and ld_flags into the registers at the next edge. While busy, ld_en has no effect.
- R3: A start sampled while idle makes busy high and raises mem_req with mem_addr equal to hl in the next cycle. mem_req stays high until mem_valid is sampled. A start sampled while busy is ignored.
- R4: The difference is acc minus the fetched byte, modulo 256. The accumulator never changes during an operation.
- R5: When a read completes, hl moves by +1, or by -1 when step_down was high at start, with 16-bit wrap. bc decrements with 16-bit wrap.
- R6: In the new flags, bit 0 (carry) keeps its old value, bit 1 is set, bit 2 is set when the new bc is nonzero, bit 6 is set when the difference is zero, and bit 7 is bit 7 of the difference.
- R7: Flag bit 4 is set when the low nibble of acc is smaller than the low nibble of the fetched byte. This is the half-borrow.
- R8: Let t be the difference minus flag bit 4. Flag bit 3 is t bit 3 and flag bit 5 is t bit 1.
- R9: With rpt_mode high at start, another iteration follows only when the new bc is nonzero and the difference is nonzero. With rpt_mode low, exactly one iteration runs.
- R10: An iteration lasts its read cycles plus 5 cycles, plus 5 more when another iteration follows. In its last cycle, iter_stb pulses high for one cycle and iter_cycles gives that total.
- R11: After the final iteration, done pulses high for one cycle together with iter_stb, and busy is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load register state (idle only) |
| ld_acc | input | 8 | Accumulator load value |
| ld_hl | input | 16 | Pointer load value |
| ld_bc | input | 16 | Counter load value |
| ld_flags | input | 8 | Flag byte load value |
| start | input | 1 | Begin an operation |
| rpt_mode | input | 1 | Repeat until counter expires or match |
| step_down | input | 1 | Decrement pointer instead of increment |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| acc | output | 8 | Accumulator |
| hl | output | 16 | Pointer |
| bc | output | 16 | Counter |
| flags | output | 8 | Flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| iter_stb | output | 1 | Iteration finished (one cycle) |
| iter_cycles | output | 8 | Cycle count of the finished iteration |

## Verification
The bench targets a pointer stepping down through 0x0000, a counter of one that ends a repeat after one step, and a counter of zero that wraps to 0xFFFF and sets parity/overflow. A design that got any of these wrong would show a wrong hl, bc or flag byte, or would stop or go on at the wrong point. A sweep of nibble combinations checks that the half-borrow and the two undocumented bits come from the borrow-corrected difference; taking them from the raw difference would go wrong whenever a half-borrow occurs. Read latencies from one to four cycles, and start or load pulses given mid-operation, check the iteration cycle counts, the strobe placement and the refusal of commands while busy.

// File: rtl/blkcmp_pkg.sv
package blkcmp_pkg;

  // Flag byte bit positions
  localparam int FLG_C  = 0;
  localparam int FLG_N  = 1;
  localparam int FLG_PV = 2;
  localparam int FLG_X  = 3;
  localparam int FLG_H  = 4;
  localparam int FLG_Y  = 5;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_HOLD  = 2'd2
  } seq_state_e;

  // Half-borrow from {result bit3, operand bit3, accumulator bit3}
  function automatic logic hb_lookup(input logic [2:0] idx);
    case (idx)
      3'd2, 3'd4, 3'd6, 3'd7: hb_lookup = 1'b1;
      default:                hb_lookup = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/blkcmp_rst_sync.sv
module blkcmp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/blkcmp_step_alu.sv
module blkcmp_step_alu
  import blkcmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic [7:0]        acc_i,
  input  logic [7:0]        mem_i,
  input  logic [7:0]        flags_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [CNT_W-1:0]  bc_i,
  input  logic              down_i,
  output logic [ADDR_W-1:0] hl_o,
  output logic [CNT_W-1:0]  bc_o,
  output logic [7:0]        flags_o,
  output logic              more_o
);
  logic [7:0] diff;
  logic [7:0] adj;
  logic       hb;

  always_comb begin
    diff = acc_i - mem_i;
    hb   = hb_lookup({diff[3], mem_i[3], acc_i[3]});
    adj  = diff - {7'd0, hb};
    bc_o = bc_i - {{(CNT_W-1){1'b0}}, 1'b1};
    if (down_i) hl_o = hl_i - {{(ADDR_W-1){1'b0}}, 1'b1};
    else        hl_o = hl_i + {{(ADDR_W-1){1'b0}}, 1'b1};

    flags_o         = 8'd0;
    flags_o[FLG_C]  = flags_i[FLG_C];
    flags_o[FLG_N]  = 1'b1;
    flags_o[FLG_PV] = (bc_o != '0);
    flags_o[FLG_X]  = adj[3];
    flags_o[FLG_H]  = hb;
    flags_o[FLG_Y]  = adj[1];
    flags_o[FLG_Z]  = (diff == 8'd0);
    flags_o[FLG_S]  = diff[7];

    more_o = (bc_o != '0) && (diff != 8'd0);
  end
endmodule

// File: rtl/blkcmp_delay_ctr.sv
module blkcmp_delay_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                     cnt_d = val_i;
    else if (dec_i && cnt_q != '0)  cnt_d = cnt_q - {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i || dec_i)  cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/blkcmp_seq.sv
module blkcmp_seq
  import blkcmp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int CYC_W    = 8,
  parameter int BASE_DLY = 5,
  parameter int RPT_DLY  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [7:0]        ld_acc,
  input  logic [ADDR_W-1:0] ld_hl,
  input  logic [CNT_W-1:0]  ld_bc,
  input  logic [7:0]        ld_flags,
  input  logic              start,
  input  logic              rpt_mode,
  input  logic              step_down,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        acc,
  output logic [ADDR_W-1:0] hl,
  output logic [CNT_W-1:0]  bc,
  output logic [7:0]        flags,
  output logic              busy,
  output logic              done,
  output logic              iter_stb,
  output logic [CYC_W-1:0]  iter_cycles
);
  localparam int DLY_W = $clog2(BASE_DLY + RPT_DLY + 1);
  localparam logic [CYC_W:0] CYC_MAX = {1'b0, {CYC_W{1'b1}}};

  logic core_rst_n;

  seq_state_e        state_q, state_d;
  logic [7:0]        acc_q, acc_d;
  logic [ADDR_W-1:0] hl_q, hl_d;
  logic [CNT_W-1:0]  bc_q, bc_d;
  logic [7:0]        flg_q, flg_d;
  logic              rpt_q, rpt_d;
  logic              down_q, down_d;
  logic              cont_q, cont_d;
  logic [CYC_W-1:0]  rd_cnt_q, rd_cnt_d;
  logic [CYC_W-1:0]  rd_len_q, rd_len_d;
  logic              stb_q, stb_d;
  logic              done_q, done_d;
  logic [CYC_W-1:0]  icyc_q, icyc_d;

  logic [ADDR_W-1:0] alu_hl;
  logic [CNT_W-1:0]  alu_bc;
  logic [7:0]        alu_flg;
  logic              alu_more;

  logic              tmr_load;
  logic [DLY_W-1:0]  tmr_val;
  logic              tmr_dec;
  logic              tmr_zero;
  logic [CYC_W:0]    cyc_sum;

  blkcmp_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  blkcmp_step_alu #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_alu (
    .acc_i   (acc_q),
    .mem_i   (mem_rdata),
    .flags_i (flg_q),
    .hl_i    (hl_q),
    .bc_i    (bc_q),
    .down_i  (down_q),
    .hl_o    (alu_hl),
    .bc_o    (alu_bc),
    .flags_o (alu_flg),
    .more_o  (alu_more)
  );

  blkcmp_delay_ctr #(.W(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .dec_i  (tmr_dec),
    .zero_o (tmr_zero)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    acc_d    = acc_q;
    hl_d     = hl_q;
    bc_d     = bc_q;
    flg_d    = flg_q;
    rpt_d    = rpt_q;
    down_d   = down_q;
    cont_d   = cont_q;
    rd_cnt_d = rd_cnt_q;
    rd_len_d = rd_len_q;
    stb_d    = 1'b0;
    done_d   = 1'b0;
    icyc_d   = icyc_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = (state_q == ST_HOLD);

    cyc_sum = {1'b0, rd_len_q} + (CYC_W+1)'(BASE_DLY)
            + (cont_q ? (CYC_W+1)'(RPT_DLY) : '0);

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_FETCH;
          rpt_d    = rpt_mode;
          down_d   = step_down;
          rd_cnt_d = {{(CYC_W-1){1'b0}}, 1'b1};
        end else if (ld_en) begin
          acc_d = ld_acc;
          hl_d  = ld_hl;
          bc_d  = ld_bc;
          flg_d = ld_flags;
        end
      end
      ST_FETCH: begin
        if (mem_valid) begin
          hl_d     = alu_hl;
          bc_d     = alu_bc;
          flg_d    = alu_flg;
          cont_d   = rpt_q & alu_more;
          rd_len_d = rd_cnt_q;
          tmr_load = 1'b1;
          tmr_val  = DLY_W'(BASE_DLY - 1)
                   + ((rpt_q & alu_more) ? DLY_W'(RPT_DLY) : '0);
          state_d  = ST_HOLD;
        end else if (rd_cnt_q != {CYC_W{1'b1}}) begin
          rd_cnt_d = rd_cnt_q + {{(CYC_W-1){1'b0}}, 1'b1};
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          stb_d  = 1'b1;
          icyc_d = (cyc_sum > CYC_MAX) ? {CYC_W{1'b1}} : cyc_sum[CYC_W-1:0];
          if (cont_q) begin
            state_d  = ST_FETCH;
            rd_cnt_d = {{(CYC_W-1){1'b0}}, 1'b1};
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q  <= ST_IDLE;
      acc_q    <= '0;
      hl_q     <= '0;
      bc_q     <= '0;
      flg_q    <= '0;
      rpt_q    <= 1'b0;
      down_q   <= 1'b0;
      cont_q   <= 1'b0;
      rd_cnt_q <= '0;
      rd_len_q <= '0;
      stb_q    <= 1'b0;
      done_q   <= 1'b0;
      icyc_q   <= '0;
    end else begin
      state_q  <= state_d;
      acc_q    <= acc_d;
      hl_q     <= hl_d;
      bc_q     <= bc_d;
      flg_q    <= flg_d;
      rpt_q    <= rpt_d;
      down_q   <= down_d;
      cont_q   <= cont_d;
      rd_cnt_q <= rd_cnt_d;
      rd_len_q <= rd_len_d;
      stb_q    <= stb_d;
      done_q   <= done_d;
      icyc_q   <= icyc_d;
    end
  end

  assign mem_req     = (state_q == ST_FETCH);
  assign mem_addr    = hl_q;
  assign acc         = acc_q;
  assign hl          = hl_q;
  assign bc          = bc_q;
  assign flags       = flg_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign iter_stb    = stb_q;
  assign iter_cycles = icyc_q;

endmodule

// File: rtl/blkcmp_seq_chk.sv
module blkcmp_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic [7:0]        acc,
  input logic [CNT_W-1:0]  bc,
  input logic [7:0]        flags,
  input logic              busy,
  input logic              done,
  input logic              iter_stb
);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(acc));

  // R5
  bc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (bc == CNT_W'($past(bc) - 1'b1)));

  // R6
  nflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (flags[1] && (flags[0] == $past(flags[0]))));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && iter_stb));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

bind blkcmp_seq blkcmp_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_valid (mem_valid),
  .acc       (acc),
  .bc        (bc),
  .flags     (flags),
  .busy      (busy),
  .done      (done),
  .iter_stb  (iter_stb)
);

// File: tb/blkcmp_seq_test.sv
`timescale 1ns/1ps
module blkcmp_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en, start, rpt_mode, step_down, mem_valid;
  logic [7:0]  ld_acc, ld_flags, mem_rdata;
  logic [15:0] ld_hl, ld_bc;
  logic        mem_req, busy, done, iter_stb;
  logic [15:0] mem_addr, hl, bc;
  logic [7:0]  acc, flags, iter_cycles;

  always #2.5 clk = ~clk;

  blkcmp_seq uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_acc(ld_acc), .ld_hl(ld_hl),
    .ld_bc(ld_bc), .ld_flags(ld_flags), .start(start), .rpt_mode(rpt_mode),
    .step_down(step_down), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .acc(acc), .hl(hl), .bc(bc),
    .flags(flags), .busy(busy), .done(done), .iter_stb(iter_stb),
    .iter_cycles(iter_cycles)
  );

  int checks = 0, failures = 0, cyc = 0;
  // reference state
  int m_acc = 0, m_hl = 0, m_bc = 0, m_f = 0;
  int m_phase = 0, m_since = 0, m_D = 0, m_L = 0;
  bit m_cont = 0, m_rpt = 0, m_down = 0;
  bit exp_stb, exp_done;
  int exp_cyc = 0;
  // stimulus requests and what was driven at the last edge
  bit start_rq = 0, ld_rq = 0, p_start = 0, p_ld = 0, p_valid = 0;
  int p_data = 0, rc = 0, lat = 1, nread = 0;
  int tgt_a = -1, tgt_v = 0;
  int q_acc = 0, q_hl = 0, q_bc = 0, q_f = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic int memf(input int a);
    if (a == tgt_a) return tgt_v;
    return ((a * 29) ^ (a >> 8) ^ 8'hA5) & 8'hFF;
  endfunction

  task automatic model_step();
    int diff, h, t, nf;
    diff = (m_acc - p_data) & 8'hFF;
    h = ((m_acc & 15) < (p_data & 15)) ? 1 : 0;
    t = (diff - h) & 8'hFF;
    m_bc = (m_bc - 1) & 16'hFFFF;
    m_hl = (m_down ? m_hl - 1 : m_hl + 1) & 16'hFFFF;
    nf = (m_f & 1) | 2 | ((m_bc != 0) ? 4 : 0) | (((t >> 3) & 1) << 3) | (h << 4)
       | (((t >> 1) & 1) << 5) | ((diff == 0) ? 64 : 0) | (diff & 128);
    m_f = nf;
    m_cont = m_rpt && (m_bc != 0) && (diff != 0);
    m_L = rc;
    rc = 0;
    m_D = 5 + (m_cont ? 5 : 0);
    m_since = 0;
    m_phase = 2;
  endtask

  task automatic finish_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > 100000) begin
      failures++; checks++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      finish_all();
    end
    exp_stb = 0; exp_done = 0;
    if (m_phase == 0) begin
      if (p_start) begin m_phase = 1; m_rpt = rpt_mode; m_down = step_down; end
      else if (p_ld) begin m_acc = q_acc; m_hl = q_hl; m_bc = q_bc; m_f = q_f; end
    end else if (m_phase == 1) begin
      if (p_valid) model_step();
    end else begin
      m_since++;
      if (m_since == m_D) begin
        exp_stb = 1; exp_cyc = m_L + m_D;
        if (m_cont) m_phase = 1;
        else begin m_phase = 0; exp_done = 1; end
      end
    end
    // compare every cycle
    chk(acc == m_acc[7:0], "R4 acc", acc, m_acc);
    chk(hl == m_hl[15:0], "R5 hl", hl, m_hl);
    chk(bc == m_bc[15:0], "R5 bc", bc, m_bc);
    chk({flags[7:6], flags[2:0]} == {m_f[7:6], m_f[2:0]}, "R6 flags S/Z/PV/N/C",
        flags, m_f);
    chk(flags[4] == m_f[4], "R7 half-borrow", flags, m_f);
    chk({flags[5], flags[3]} == {m_f[5], m_f[3]}, "R8 undocumented bits", flags, m_f);
    chk(mem_req == (m_phase == 1), "R3 mem_req", mem_req, m_phase == 1);
    if (m_phase == 1) chk(mem_addr == m_hl[15:0], "R3 mem_addr", mem_addr, m_hl);
    chk(iter_stb == exp_stb, "R10 iter_stb", iter_stb, exp_stb);
    if (exp_stb) begin
      chk(iter_cycles == exp_cyc[7:0], "R10 iter_cycles", iter_cycles, exp_cyc);
      chk(busy == m_cont, "R9 continuation", busy, m_cont);
    end
    chk(done == exp_done, "R11 done", done, exp_done);
    chk(busy == (m_phase != 0), "R11 busy", busy, m_phase != 0);
    // drive next inputs
    p_start = start_rq; start = start_rq; start_rq = 0;
    p_ld = ld_rq; ld_en = ld_rq; ld_rq = 0;
    ld_acc = q_acc[7:0]; ld_hl = q_hl[15:0]; ld_bc = q_bc[15:0]; ld_flags = q_f[7:0];
    p_valid = 0; mem_valid = 0;
    if (mem_req) begin
      rc++;
      if (rc == 1) begin lat = 1 + (nread % 4); nread++; end
      if (rc == lat) begin
        p_valid = 1; mem_valid = 1;
        p_data = memf(mem_addr); mem_rdata = p_data[7:0];
      end
    end
  endtask

  task automatic do_load(input int a, input int h, input int b, input int f);
    q_acc = a; q_hl = h; q_bc = b; q_f = f; ld_rq = 1;
    tick(); tick();
    chk(acc == a[7:0] && hl == h[15:0] && bc == b[15:0] && flags == f[7:0],
        "R2 load", {acc, flags}, {a[7:0], f[7:0]});
  endtask

  task automatic run(input bit rep, input bit down, input bit noise);
    rpt_mode = rep; step_down = down; start_rq = 1;
    tick();
    for (int i = 0; i < 5000; i++) begin
      tick();
      if (noise && i == 2) begin
        start_rq = 1; ld_rq = 1;
        q_acc = 8'h99; q_hl = 16'h4444; q_bc = 16'h0777; q_f = 8'hFF;
      end
      if (m_phase == 0 && !start_rq && !ld_rq) break;
    end
    tick();
  endtask

  initial begin
    rst_n = 0; ld_en = 0; start = 0; rpt_mode = 0; step_down = 0;
    mem_valid = 0; mem_rdata = 0; ld_acc = 0; ld_hl = 0; ld_bc = 0; ld_flags = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    chk({acc, flags} == 16'h0 && hl == 0 && bc == 0, "R1 regs", {acc, flags}, 0);
    chk({busy, done, mem_req, iter_stb} == 4'b0, "R1 controls",
        {busy, done, mem_req, iter_stb}, 0);

    // single step, match, carry preserved
    tgt_a = 16'h1000; tgt_v = 8'h3C;
    do_load(8'h3C, 16'h1000, 3, 8'h01);
    run(0, 0, 0);
    chk(hl == 16'h1001 && bc == 16'h0002, "R5 single step", hl, 16'h1001);
    chk(flags[6] && flags[0] && !flags[4], "R6 match flags", flags, 8'h47);

    // start and load while busy are ignored (R3, R2)
    do_load(8'h20, 16'h0200, 6, 8'h00);
    run(1, 0, 1);
    chk(acc == 8'h20, "R2 load ignored while busy", acc, 8'h20);

    // repeat search with a match on the third byte
    tgt_a = 16'h2002; tgt_v = 8'h55;
    do_load(8'h55, 16'h2000, 10, 8'h00);
    run(1, 0, 0);
    chk(hl == 16'h2003 && bc == 16'd7, "R9 stop on match", bc, 7);

    // counter one, step down through zero
    tgt_a = -1;
    do_load(8'h01, 16'h0000, 1, 8'h01);
    run(1, 1, 0);
    chk(hl == 16'hFFFF && bc == 16'h0000 && !flags[2], "R5 wrap down", hl, 16'hFFFF);

    // counter zero, single step wraps to 0xFFFF and sets PV
    do_load(8'h80, 16'hFFFF, 0, 8'h00);
    run(0, 0, 0);
    chk(bc == 16'hFFFF && hl == 16'h0000 && flags[2], "R6 counter wrap", bc, 16'hFFFF);

    // repeat down with no match until counter expires
    tgt_a = -1;
    do_load(8'hEE, 16'h3005, 5, 8'h00);
    run(1, 1, 0);
    chk(bc == 16'h0000 || flags[6], "R9 expiry", bc, 0);

    // nibble sweep for half-borrow and undocumented bits
    for (int i = 0; i < 16; i++) begin
      tgt_a = 16'h5000 + i; tgt_v = ((i * 8'h13) ^ 8'h38) & 8'hFF;
      do_load((i << 4) | (15 - i), 16'h5000 + i, 2, i & 1);
      run(0, 0, 0);
    end

    finish_all();
  end
endmodule